// File: doc/BRIEF.md
# Parallel NOR Flash Command Emulator

This block is a small, clocked stand-in for the command side of a word-wide parallel NOR flash. A host drives chip enable, output enable, write enable, an address and a 16-bit data word. The block samples these on its system clock. Reads return words from a small internal array. Writes are decoded as multi-cycle unlock and command sequences. These sequences program a word, erase one sector or erase every unlocked sector.

The array is split into equal sectors, each selected by the top address bits. An input vector holds one lock bit per sector. Each program or erase runs for a fixed number of clock cycles, and `ready` is low for that whole time. While the block is busy, reads return a status word in which one bit flips on every new read. An active-low reset aborts any running operation and turns the data outputs off.

Top module: `nor_cmd_emu`

## Requirements
- R1: `dout_en` is high only while `rst_n` is high, `ce_n` and `oe_n` are low and `we_n` is high. While the block is ready, `dout` then shows the array word at `addr`. While `dout_en` is low, `dout` is zero, which stands for a released bus.
- R2: A write cycle runs while `ce_n` and `we_n` are both low and `oe_n` is high. The address is taken at the first clock on which both enables are low. The data is taken at the first clock on which either enable is high again.
- R3: Only `din[7:0]` carries the command code. The upper byte of a command cycle has no effect.
- R4: A program is the sequence AAh@555h, 55h@2AAh, A0h@555h, followed by a write of the data to the target address. Only the low AW address bits are compared. The stored word becomes the old word ANDed with the data, so bits only go from 1 to 0.
- R5: A sector erase is the sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, followed by 30h at any address in the target sector. Every word of that sector (address bits [AW-1:AW-SW]) becomes FFFFh and no other sector changes.
- R6: A chip erase uses the same five cycles and then ends with 10h@555h. It sets every word of each sector whose `sector_lock` bit is 0 to FFFFh, and leaves locked sectors unchanged.
- R7: A program or sector erase aimed at a locked sector changes no data and holds `ready` low for exactly LOCK_CYC cycles.
- R8: `ready` goes low on the clock that takes the last write's data. It stays low for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase. Writes made while `ready` is low are ignored.
- R9: While `ready` is low, a read returns a status word. Bit 6 flips at the start of each new read and all other bits are 0.
- R10: A write that does not match the next expected cycle of a sequence returns the decoder to idle. It changes no data and starts no operation.
- R11: While `rst_n` is low, `dout_en` is low and `ready` is high. An operation that is running is dropped with no data change, and the decoder restarts idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset, aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Word address |
| din | input | 16 | Write data and command code |
| sector_lock | input | 2**SW | One lock bit per sector, 1 = locked |
| dout | output | 16 | Read data or status word |
| dout_en | output | 1 | High while the block drives `dout` |
| ready | output | 1 | Low while an internal operation runs |

## Verification
Program, sector erase and chip erase are each run with and without locked sectors. This separates the lock test done when a command starts from the sector mask applied when a chip erase completes. Further runs cover:
- a broken unlock sequence, which must change nothing;
- command bytes carrying a non-zero upper byte;
- a write whose enables fall and rise in crossed order, which shows that address and data are taken on different edges;
- a complete program sequence issued during an erase, which must be dropped;
- a reset during an erase, which must leave the array untouched.

A behavioural model in the bench predicts `ready`, `dout_en` and `dout` on every clock, so the cycle counts and the toggling status bit are checked exactly.

// File: rtl/nor_cmd_emu.sv
module nor_cmd_emu #(
  parameter int AW        = 8,
  parameter int SW        = 2,
  parameter int CW        = 8,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 40,
  parameter int LOCK_CYC  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce_n,
  input  logic                 oe_n,
  input  logic                 we_n,
  input  logic [AW-1:0]        addr,
  input  logic [15:0]          din,
  input  logic [(1<<SW)-1:0]   sector_lock,
  output logic [15:0]          dout,
  output logic                 dout_en,
  output logic                 ready
);
  localparam int DEPTH = 1 << AW;
  localparam int SSZ   = AW - SW;
  localparam logic [AW-1:0] A1 = AW'(12'h555);
  localparam logic [AW-1:0] A2 = AW'(12'h2AA);
  localparam logic [CW-1:0] P_N = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] E_N = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] L_N = CW'(LOCK_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PRG, S_E0, S_E1, S_E2} seq_t;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_t;

  logic [15:0]   mem [DEPTH];
  logic          wr_q, rd_q, busy, tog, start;
  logic [AW-1:0] a_lat, op_a;
  logic [15:0]   op_d;
  logic [CW-1:0] cnt;
  seq_t          seq, seq_n;
  op_t           op, start_op;

  wire       wr_act  = !ce_n && !we_n && oe_n;
  wire       rd_act  = !ce_n && !oe_n && we_n;
  wire       wr_done = wr_q && !wr_act;
  wire [7:0] cmd     = din[7:0];
  wire       at1     = (a_lat == A1);
  wire       at2     = (a_lat == A2);
  wire       locked  = sector_lock[a_lat[AW-1 -: SW]];
  wire       finish  = busy && (cnt == '0);

  function automatic logic [SW-1:0] sect_of(int i);
    return SW'(i >> SSZ);
  endfunction

  always_comb begin
    seq_n    = S_IDLE;
    start    = 1'b0;
    start_op = OP_NONE;
    case (seq)
      S_IDLE: if (at1 && cmd == 8'hAA) seq_n = S_U1;
      S_U1:   if (at2 && cmd == 8'h55) seq_n = S_U2;
      S_U2:   if (at1 && cmd == 8'hA0) seq_n = S_PRG;
              else if (at1 && cmd == 8'h80) seq_n = S_E0;
      S_PRG:  begin start = 1'b1; start_op = OP_PROG; end
      S_E0:   if (at1 && cmd == 8'hAA) seq_n = S_E1;
      S_E1:   if (at2 && cmd == 8'h55) seq_n = S_E2;
      S_E2:   if (cmd == 8'h30) begin start = 1'b1; start_op = OP_SECT; end
              else if (at1 && cmd == 8'h10) begin start = 1'b1; start_op = OP_CHIP; end
      default: seq_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0; rd_q <= 1'b0; busy <= 1'b0; tog <= 1'b0;
      seq <= S_IDLE; op <= OP_NONE; cnt <= '0;
      a_lat <= '0; op_a <= '0; op_d <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act && !wr_q) a_lat <= addr;
      if (busy && rd_act && !rd_q) tog <= ~tog;
      if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end else if (wr_done) begin
        seq <= seq_n;
        if (start) begin
          busy <= 1'b1;
          op_a <= a_lat;
          op_d <= din;
          if (start_op != OP_CHIP && locked) begin
            op  <= OP_NONE;
            cnt <= L_N;
          end else begin
            op  <= start_op;
            cnt <= (start_op == OP_PROG) ? P_N : E_N;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && finish) begin
      if (op == OP_PROG) mem[op_a] <= mem[op_a] & op_d;
      for (int i = 0; i < DEPTH; i++) begin
        if ((op == OP_CHIP && !sector_lock[sect_of(i)]) ||
            (op == OP_SECT && sect_of(i) == op_a[AW-1 -: SW]))
          mem[i] <= 16'hFFFF;
      end
    end
  end

  assign ready   = !busy;
  assign dout_en = rst_n && rd_act;
  assign dout    = !dout_en ? 16'h0000 : busy ? {9'b0, tog, 6'b0} : mem[addr];

  a_r4_prog_and: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && op == OP_PROG) |=> mem[op_a] == ($past(mem[op_a]) & $past(op_d)));
  a_r8_start_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_done));
  a_r8_decoder_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> seq == S_IDLE);
  a_r7_lock_short: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && op == OP_NONE) |-> cnt == L_N);
  a_r9_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_en) |-> (dout[15:7] == '0 && dout[5:0] == '0));
endmodule

// File: tb/nor_cmd_emu_tb.sv
module nor_cmd_emu_tb;
  localparam int AW = 8, SW = 2, PC = 6, EC = 40, LC = 3;
  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [3:0] sector_lock = '0;
  logic [15:0] dout;
  logic dout_en, ready;
  int checks = 0, errors = 0;
  int run = 0, last_run = 0;
  bit done = 0;

  nor_cmd_emu #(.AW(AW), .SW(SW), .CW(8), .PROG_CYC(PC), .ERASE_CYC(EC), .LOCK_CYC(LC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .din(din), .sector_lock(sector_lock), .dout(dout), .dout_en(dout_en), .ready(ready));

  always #5 clk = ~clk;

  // behavioural reference model
  int m_mem[256];
  bit m_wq, m_rq, m_tg;
  int m_alat, m_step, m_left, m_op, m_a, m_d;
  initial foreach (m_mem[i]) m_mem[i] = 16'hFFFF;

  task automatic m_start(int o, int a, int d);
    m_a = a; m_d = d;
    if (o != 3 && sector_lock[a >> 6]) begin m_op = 0; m_left = LC; end
    else begin m_op = o; m_left = (o == 1) ? PC : EC; end
  endtask

  task automatic m_apply();
    for (int i = 0; i < 256; i++) begin
      if (m_op == 1 && i == m_a) m_mem[i] = m_mem[i] & m_d;
      if (m_op == 2 && (i >> 6) == (m_a >> 6)) m_mem[i] = 16'hFFFF;
      if (m_op == 3 && !sector_lock[i >> 6]) m_mem[i] = 16'hFFFF;
    end
  endtask

  task automatic m_decode(int a, int d);
    int c = d & 255;
    int nx = 0;
    case (m_step)
      0: if (a == 'h55 && c == 'hAA) nx = 1;
      1: if (a == 'hAA && c == 'h55) nx = 2;
      2: if (a == 'h55 && c == 'hA0) nx = 3; else if (a == 'h55 && c == 'h80) nx = 4;
      3: m_start(1, a, d);
      4: if (a == 'h55 && c == 'hAA) nx = 5;
      5: if (a == 'hAA && c == 'h55) nx = 6;
      6: if (c == 'h30) m_start(2, a, d); else if (c == 'h10 && a == 'h55) m_start(3, a, d);
      default: nx = 0;
    endcase
    m_step = nx;
  endtask

  always @(posedge clk) begin
    bit w, r;
    w = !ce_n && !we_n && oe_n;
    r = !ce_n && !oe_n && we_n;
    if (!rst_n) begin
      m_wq = 0; m_rq = 0; m_tg = 0; m_step = 0; m_left = 0; m_alat = 0;
    end else begin
      if (m_left > 0 && r && !m_rq) m_tg = !m_tg;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_apply();
      end else if (m_wq && !w) m_decode(m_alat, int'(din));
      if (w && !m_wq) m_alat = int'(addr);
      m_wq = w; m_rq = r;
    end
  end

  // per-clock comparison against the model (R1, R8, R9)
  always @(posedge clk) begin
    logic en_e, rdy_e;
    logic [15:0] out_e;
    #2;
    en_e  = rst_n && !ce_n && !oe_n && we_n;
    rdy_e = (m_left == 0);
    out_e = !en_e ? 16'h0 : (m_left > 0) ? 16'(m_tg) << 6 : 16'(m_mem[addr]);
    checks++;
    if (dout_en !== en_e || ready !== rdy_e || dout !== out_e) begin
      errors++;
      $display("FAIL R1/R8/R9 model t=%0t: en=%b rdy=%b dout=%h expected en=%b rdy=%b dout=%h",
               $time, dout_en, ready, dout, en_e, rdy_e, out_e);
    end
    if (!ready) run++;
    else if (run > 0) begin last_run = run; run = 0; end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = AW'(a); din = 16'(d);
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
    @(posedge clk); #2 v = int'(dout);
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_ready();
    @(posedge clk); #3;
    while (!ready) begin @(posedge clk); #3; end
    @(posedge clk); #3;
  endtask

  task automatic prog(int a, int d);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0); wr(a, d);
  endtask

  task automatic erase(int a, int c);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr(a, c);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v, v2;
    repeat (3) @(posedge clk);
    #2;
    check("R11 reset ready", int'(ready), 1);
    check("R11 reset dout_en", int'(dout_en), 0);
    @(negedge clk); rst_n = 1;

    erase('h555, 'h10); wait_ready();
    check("R6 busy length chip erase", last_run, EC);
    rd('h10, v); check("R5 erased word", v, 'hFFFF);

    prog('h10, 'h1234); wait_ready();
    check("R8 busy length program", last_run, PC);
    rd('h10, v); check("R4 program", v, 'h1234);
    prog('h10, 'hFF0F); wait_ready();
    rd('h10, v); check("R4 only 1 to 0", v, 'h1204);

    wr('h555, 'h5AAA); wr('h2AA, 'hC355); wr('h555, 'h77A0); wr('h20, 'h00FF); wait_ready();
    rd('h20, v); check("R3 upper byte ignored", v, 'h00FF);

    @(negedge clk); ce_n = 1; oe_n = 0; addr = 'h20;
    @(posedge clk); #2 check("R1 no drive without ce", int'(dout_en), 0);
    @(negedge clk); oe_n = 1;

    erase('h555, 'h10);
    rd('h10, v); rd('h10, v2);
    check("R9 status toggles", (v ^ v2), 'h40);
    check("R9 status other bits", v & 'hFFBF, 0);
    prog('h30, 'h0000);
    wait_ready();
    rd('h30, v); check("R8 write during busy ignored", v, 'hFFFF);

    prog('h45, 'h1111); wait_ready();
    prog('h85, 'h2222); wait_ready();
    erase('h47, 'h30); wait_ready();
    check("R5 busy length sector erase", last_run, EC);
    rd('h45, v); check("R5 target sector erased", v, 'hFFFF);
    rd('h85, v); check("R5 other sector kept", v, 'h2222);

    sector_lock = 4'b0100;
    prog('h90, 'h0000); wait_ready();
    check("R7 locked program short busy", last_run, LC);
    rd('h90, v); check("R7 locked program no change", v, 'hFFFF);
    erase('h85, 'h30); wait_ready();
    check("R7 locked erase short busy", last_run, LC);
    rd('h85, v); check("R7 locked erase no change", v, 'h2222);

    prog('h10, 'h0F0F); wait_ready();
    erase('h555, 'h10); wait_ready();
    rd('h85, v); check("R6 locked sector kept", v, 'h2222);
    rd('h10, v); check("R6 unlocked sector erased", v, 'hFFFF);
    sector_lock = '0;

    wr('h555, 'hAA); wr('h033, 'h55); wr('h555, 'hA0); wr('h10, 'h0000);
    @(posedge clk); #2 check("R10 no operation started", int'(ready), 1);
    rd('h10, v); check("R10 no data change", v, 'hFFFF);

    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0);
    @(negedge clk); we_n = 0; ce_n = 1; addr = 'h11; din = 'h0000;
    @(negedge clk); ce_n = 0; addr = 'h50;
    @(negedge clk); addr = 'h12; din = 'h0000;
    @(negedge clk); ce_n = 1; din = 'h0F0F; addr = 'h13;
    @(negedge clk); we_n = 1;
    wait_ready();
    rd('h50, v); check("R2 address on late fall, data on early rise", v, 'h0F0F);

    prog('h20, 'h0F00); wait_ready();
    erase('h555, 'h10);
    repeat (4) @(negedge clk);
    ce_n = 0; oe_n = 0; rst_n = 0;
    @(posedge clk); #2;
    check("R11 dout_en low in reset", int'(dout_en), 0);
    check("R11 ready high in reset", int'(ready), 1);
    @(negedge clk); ce_n = 1; oe_n = 1; rst_n = 1;
    rd('h20, v); check("R11 aborted erase left data", v, 'h0F00);
    prog('h20, 'h0300); wait_ready();
    rd('h20, v); check("R11 decoder idle after reset", v, 'h0300);

    repeat (3) @(posedge clk);
    summary();
  end
endmodule